// File: doc/BRIEF.md
# Configurable GPIO Port with Interrupts

An eight-pin general-purpose I/O port programmed through a small register bus. Each pin can be set up on its own as a push-pull output, a plain input, or an input that raises an interrupt. Per-pin configuration is held in three registers: an output latch, a direction mask and an interrupt-enable mask. One port-wide field selects which pin condition raises the interrupt.

Pin inputs pass through a two-flop synchronizer. Readback and event detection both use the synchronized levels. A read of the data register mixes two sources. Output pins return their latch bits. Input pins return their synchronized levels. Writes to the data register always land in the latch, including the bits of pins that are currently inputs. This lets software preload the level a pin will drive before it turns that pin into an output. The same mixing means that a read-modify-write of the data register copies pin levels into the latch bits of input pins. The block keeps this behaviour exactly as it is.

The pin side uses a tristate-style interface: a level to drive, an output enable, and the sampled input. All enabled input pins share one combined interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, interrupt-enable, latch and sensitivity registers all read zero, `pin_oe_o` is zero and `irq_o` is low.
- R2: Direction bit x controls pin x. A 0 makes the pin an input and a 1 makes it an output, and `pin_oe_o[x]` follows that bit in the cycle after the write.
- R3: A read at address 0 returns the latch bit for every output pin and the synchronized pin level for every input pin. The synchronized level reflects a change at `pin_in_i` two rising clock edges after the change.
- R4: A write at address 0 always updates the latch, whatever the pin directions are. `pin_out_o` shows the latch on every bit, but an input pin is not driven because its `pin_oe_o` bit stays 0.
- R5: When a pin is switched from input to output, it drives the value already held in its latch in the same cycle its enable rises.
- R6: An input pin raises no interrupt while its interrupt-enable bit (address 2, bit x) is 0.
- R7: Sensitivity is written to address 3, bits [1:0], and applies to every enabled input pin. The encodings are: 00 = interrupt while the synchronized level is low (a falling edge is also covered), 01 = rising edge, 10 = falling edge, 11 = either edge. An edge event makes `irq_o` high for exactly one cycle, starting two clock edges after the change at `pin_in_i`.
- R8: An output pin never raises an interrupt, whatever its interrupt-enable bit holds.
- R9: Reading address 0 and writing the value back puts the pin levels of the input pins into their latch bits. A later switch of those pins to outputs then drives those levels, not the earlier latch contents.
- R10: `irq_o` is the OR of the events from all enabled input pins. The register map is 0 = data, 1 = direction, 2 = interrupt enable, 3 = sensitivity (bits above [1:0] read as zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | WIDTH (8) | Write data |
| reg_rdata_o | output | WIDTH (8) | Combinational read data for `reg_addr_i` |
| pin_in_i | input | WIDTH (8) | Sampled pin levels (asynchronous) |
| pin_out_o | output | WIDTH (8) | Level to drive on each pin (the latch) |
| pin_oe_o | output | WIDTH (8) | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong latch bit stays hidden while its pin is an input. It shows on `pin_out_o` right after the write. It shows on `pin_oe_o`-qualified drive and data readback only once the pin is turned into an output. For this reason the bench checks the latch both before and after each direction switch. Faults in the synchronizer or in the previous-level register show up as an interrupt pulse that comes one cycle early or late, or lasts the wrong length. The bench therefore samples `irq_o` at the exact cycle of the event and again in the cycle after it. A wrong mask or sensitivity decode shows as an interrupt from a disabled pin, an output pin, or an edge of the wrong polarity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SENSE_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_DIR   = 2'd1,
    REG_IEN   = 2'd2,
    REG_SENSE = 2'd3
  } reg_sel_e;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [WIDTH-1:0]      wdata_i,
  input  logic [WIDTH-1:0]      pin_sync_i,
  output logic [WIDTH-1:0]      rdata_o,
  output logic [WIDTH-1:0]      latch_o,
  output logic [WIDTH-1:0]      dir_o,
  output logic [WIDTH-1:0]      ien_o,
  output sense_e                sense_o
);
  localparam int unsigned PAD_W = WIDTH - SENSE_W;

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_q, dir_q, ien_q;
  sense_e           sense_q;

  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      sense_q <= SENSE_LOW;
    end else if (wr_i) begin
      case (sel)
        REG_DATA:  latch_q <= wdata_i;  // latch written regardless of direction
        REG_DIR:   dir_q   <= wdata_i;
        REG_IEN:   ien_q   <= wdata_i;
        REG_SENSE: sense_q <= sense_e'(wdata_i[SENSE_W-1:0]);
        default:   ;
      endcase
    end
  end

  // input pins read live level, output pins read latch
  always_comb begin
    case (sel)
      REG_DATA:  rdata_o = (dir_q & latch_q) | (~dir_q & pin_sync_i);
      REG_DIR:   rdata_o = dir_q;
      REG_IEN:   rdata_o = ien_q;
      REG_SENSE: rdata_o = {{PAD_W{1'b0}}, sense_q};
      default:   rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign ien_o   = ien_q;
  assign sense_o = sense_q;

  p_latch_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_DATA) |=> (latch_q == $past(wdata_i)));

  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel == REG_DIR) |=> $stable(dir_q));

  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel == REG_DATA) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] ien_i,
  input  sense_e           sense_i,
  output logic             irq_o
);
  logic [WIDTH-1:0] prev_q, rise, fall, evt, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    case (sense_i)
      SENSE_LOW:  evt = ~sync_i;
      SENSE_RISE: evt = rise;
      SENSE_FALL: evt = fall;
      SENSE_BOTH: evt = rise | fall;
      default:    evt = '0;
    endcase
  end

  assign mask  = ~dir_i & ien_i;
  assign irq_o = |(evt & mask);

  p_edge_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_i != SENSE_LOW && sync_i == prev_q) |-> !irq_o);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [WIDTH-1:0] reg_wdata_i,
  output logic [WIDTH-1:0] reg_rdata_o,
  input  logic [WIDTH-1:0] pin_in_i,
  output logic [WIDTH-1:0] pin_out_o,
  output logic [WIDTH-1:0] pin_oe_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] pin_sync, latch, dir, ien;
  sense_e           sense;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pin_in_i),
    .sync_o (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pin_sync_i(pin_sync),
    .rdata_o   (reg_rdata_o),
    .latch_o   (latch),
    .dir_o     (dir),
    .ien_o     (ien),
    .sense_o   (sense)
  );

  gpio_irq #(.WIDTH(WIDTH)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (pin_sync),
    .dir_i  (dir),
    .ien_i  (ien),
    .sense_i(sense),
    .irq_o  (irq_o)
  );

  assign pin_out_o = latch;
  assign pin_oe_o  = dir;

  p_irq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(~pin_oe_o & ien));
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pins = '0;
  logic [7:0] pout, poe;
  logic       irq;
  int         checks = 0;
  int         failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_in_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // change pins, sample irq at event cycle (a) and one cycle later (b)
  task automatic pin_step(input logic [7:0] v, output logic a, output logic b);
    @(negedge clk); pins = v;
    @(posedge clk); @(posedge clk); @(negedge clk); a = irq;
    @(posedge clk); @(negedge clk); b = irq;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    read_reg(2'd0, d); chk("R1 data", d, 8'h00);
    read_reg(2'd1, d); chk("R1 dir", d, 8'h00);
    read_reg(2'd2, d); chk("R1 ien", d, 8'h00);
    read_reg(2'd3, d); chk("R1 sense", d, 8'h00);
    chk("R1 oe", poe, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_direction_preload;
    logic [7:0] d;
    logic a, b;
    write_reg(2'd0, 8'hA5);
    chk("R4 latch on out", pout, 8'hA5);
    chk("R4 input undriven", poe, 8'h00);
    read_reg(2'd0, d); chk("R3 input reads pin", d, 8'h00);
    write_reg(2'd1, 8'h0F);
    chk("R2 oe follows dir", poe, 8'h0F);
    chk("R5 preload driven", pout & poe, 8'h05);
    read_reg(2'd1, d); chk("R10 dir readback", d, 8'h0F);
    read_reg(2'd0, d); chk("R3 mixed readback", d, 8'h05);
    pin_step(8'hF0, a, b);
    read_reg(2'd0, d); chk("R3 live pin level", d, 8'hF5);
    @(negedge clk); pins = 8'h30; @(posedge clk); @(negedge clk); addr = 2'd0; #1;
    chk("R3 one edge not yet", rdata, 8'hF5);
    @(posedge clk); @(negedge clk); #1;
    chk("R3 two edges seen", rdata, 8'h35);
    pin_step(8'hF0, a, b);
  endtask

  task automatic t_rmw;
    logic [7:0] d;
    read_reg(2'd0, d); chk("R9 rmw read", d, 8'hF5);
    write_reg(2'd0, d);
    write_reg(2'd1, 8'hFF);
    chk("R9 corrupted latch driven", pout, 8'hF5);
    read_reg(2'd0, d); chk("R9 readback outputs", d, 8'hF5);
  endtask

  task automatic t_irq;
    logic a, b;
    logic [7:0] d;
    write_reg(2'd1, 8'h00);
    write_reg(2'd0, 8'h00);
    pin_step(8'h00, a, b);
    chk("R6 low level masked", {7'b0, a}, 8'h00);
    write_reg(2'd3, 8'h01);
    read_reg(2'd3, d); chk("R10 sense readback", d, 8'h01);
    pin_step(8'h01, a, b);
    chk("R6 disabled rise", {7'b0, a}, 8'h00);
    pin_step(8'h00, a, b);
    write_reg(2'd2, 8'h01);
    pin_step(8'h01, a, b);
    chk("R7 rise event", {7'b0, a}, 8'h01);
    chk("R7 rise one cycle", {7'b0, b}, 8'h00);
    pin_step(8'h00, a, b);
    chk("R7 rise ignores fall", {7'b0, a}, 8'h00);
    write_reg(2'd3, 8'h02);
    pin_step(8'h01, a, b);
    chk("R7 fall ignores rise", {7'b0, a}, 8'h00);
    pin_step(8'h00, a, b);
    chk("R7 fall event", {7'b0, a}, 8'h01);
    chk("R7 fall one cycle", {7'b0, b}, 8'h00);
    write_reg(2'd3, 8'h03);
    pin_step(8'h01, a, b);
    chk("R7 both rise", {7'b0, a}, 8'h01);
    chk("R7 both pulse end", {7'b0, b}, 8'h00);
    pin_step(8'h00, a, b);
    chk("R7 both fall", {7'b0, a}, 8'h01);
    write_reg(2'd3, 8'h00);
    chk("R7 low level now", {7'b0, irq}, 8'h01);
    pin_step(8'h01, a, b);
    chk("R7 high level quiet", {7'b0, a}, 8'h00);
    pin_step(8'h00, a, b);
    chk("R7 low level held a", {7'b0, a}, 8'h01);
    chk("R7 low level held b", {7'b0, b}, 8'h01);
    write_reg(2'd3, 8'h03);
    write_reg(2'd2, 8'hFF);
    write_reg(2'd1, 8'h01);
    chk("R8 quiet after config", {7'b0, irq}, 8'h00);
    pin_step(8'h01, a, b);
    chk("R8 output pin no irq", {7'b0, a}, 8'h00);
    pin_step(8'h09, a, b);
    chk("R10 other pin ORed", {7'b0, a}, 8'h01);
    pin_step(8'h01, a, b);
    chk("R10 other pin fall", {7'b0, a}, 8'h01);
    write_reg(2'd2, 8'h80);
    pin_step(8'h21, a, b);
    chk("R6 pin5 masked", {7'b0, a}, 8'h00);
    pin_step(8'hA1, a, b);
    chk("R10 pin7 enabled", {7'b0, a}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_direction_preload();
    t_rmw();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule